// File: doc/BRIEF.md
# Debounced Priority Keypad with Auto-Repeat

This block watches four push-buttons that are sampled on one system clock. Each line is brought into the clock domain. Each line is then filtered, so that a level counts only after it has held for a minimum time. When several keys are held at once, a fixed priority picks one of them. Each accepted press of the chosen key produces a one-cycle event strobe together with the key's index. A key that stays down produces repeat events. The first repeat comes after a long initial delay, and later repeats follow at a shorter fixed spacing. Repeats stop when the key is released.

A level flag tells the consumer whether any filtered key is currently down. All three time constants are counted in clock cycles and are parameters. A 10 MHz clock gives 500000, 10000000 and 5000000 cycles for 50 ms, 1 s and 0.5 s. A bench can use small values. Reset asserts asynchronously. Reset must be released in step with the clock.

Top module: `prio_keypad`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with all keys released, `key_valid`, `key_held` and `key_idx` are all zero, and every key counts as released.
- R2: `key_n[i]` is key i and is active-low (0 means pressed). It passes through two synchronizing flops. A level change on a key is accepted only after the synchronized level has differed from the accepted one for `DEBOUNCE_CYC` consecutive cycles. A shorter press produces no event.
- R3: An accepted press of the winning key from an idle keypad raises `key_valid` for exactly one cycle, with `key_idx` equal to the key number. This happens on the `DEBOUNCE_CYC`+3rd rising edge after the pin changes.
- R4: When several filtered keys are down, the reported index is the lowest-numbered one. Key 0 wins over all others and key 3 loses to all others.
- R5: `key_held` is high exactly when at least one filtered key is down, and it is registered with the same latency as the event strobe.
- R6: While the winner stays down, a repeat event follows `HOLD_CYC` cycles after its first event. Further repeat events then follow every `REPEAT_CYC` cycles.
- R7: When the winning key changes, the new winner immediately gives one fresh event. This includes the case where releasing a higher-priority key uncovers a lower-priority one. The repeat timing restarts, so the next event from that key comes `HOLD_CYC` cycles later.
- R8: Release is filtered like a press. A release glitch shorter than `DEBOUNCE_CYC` cycles neither ends the hold nor shifts the repeat timing.
- R9: `key_idx` keeps the index of the latest event until the next event.
- R10: After a filtered release, pressing the same key again gives a new first event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion, synchronous release |
| key_n | input | NUM_KEYS | Raw active-low key lines, bit i is key i |
| key_valid | output | 1 | One-cycle event strobe (first press or repeat) |
| key_idx | output | IDX_W | Index of the key of the latest event |
| key_held | output | 1 | High while any filtered key is down |

## Verification
Two functions can fall on the same rising edge. One is a due auto-repeat of a held key. The other is the acceptance of a higher-priority key that takes over as winner. The bench holds key 2 and presses key 0 exactly `HOLD_CYC` cycles later, so that key 0's filter completes on the very edge where key 2's first repeat is due. The correct result has three parts: a single strobe carrying index 0, no repeat for key 2, and key 0's next event a full `HOLD_CYC` later. This is checked both by directed counts and by a cycle-by-cycle reference model.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

  // Repeat phase of the event stage: waiting for the first repeat or for
  // a subsequent one.
  typedef enum logic {
    PH_FIRST = 1'b0,
    PH_AGAIN = 1'b1
  } rpt_phase_e;

  // Width of a counter that must reach lim-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim > 1) ? $clog2(lim) : 1;
  endfunction

endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_n,
  output logic [WIDTH-1:0] down
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] safe_q;

  // Reset value is "released" (line high).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      safe_q <= '1;
    end else begin
      meta_q <= raw_n;
      safe_q <= meta_q;
    end
  end

  assign down = ~safe_q;

endmodule

// File: rtl/kp_filter.sv
module kp_filter #(
  parameter int unsigned SETTLE_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_dn,
  output logic flt_dn
);

  localparam int unsigned CW = keypad_pkg::cnt_width(SETTLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          differ;
  logic          cnt_en;

  assign differ = (raw_dn != lvl_q);
  // The counter only moves while the input disagrees or must be cleared.
  assign cnt_en = differ || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!differ) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      lvl_d = raw_dn;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign flt_dn = lvl_q;

endmodule

// File: rtl/kp_prio.sv
module kp_prio #(
  parameter int unsigned NUM_KEYS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input  logic [NUM_KEYS-1:0] down,
  output logic                any_dn,
  output logic [IDX_W-1:0]    win_idx
);

  // Lowest index wins: scan from the top so the lowest set bit lands last.
  always_comb begin
    any_dn  = |down;
    win_idx = '0;
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (down[i]) win_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/kp_repeat.sv
module kp_repeat #(
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned HOLD_CYC   = 10000000,
  parameter int unsigned REPEAT_CYC = 5000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_any,
  input  logic [IDX_W-1:0] win_idx,
  output logic             ev_valid,
  output logic [IDX_W-1:0] ev_idx,
  output logic             held
);
  import keypad_pkg::*;

  localparam int unsigned TMAX = (HOLD_CYC > REPEAT_CYC) ? HOLD_CYC : REPEAT_CYC;
  localparam int unsigned TW   = cnt_width(TMAX);
  localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] REP_LAST  = TW'(REPEAT_CYC - 1);

  rpt_phase_e       ph_q, ph_d;
  logic [TW-1:0]    tm_q, tm_d;
  logic             prv_any_q;
  logic [IDX_W-1:0] prv_idx_q;
  logic             ev_q, ev_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             held_q;
  logic             fresh;
  logic             due;
  logic [TW-1:0]    lim;

  assign fresh = win_any && (!prv_any_q || (win_idx != prv_idx_q));
  assign lim   = (ph_q == PH_AGAIN) ? REP_LAST : HOLD_LAST;
  assign due   = win_any && !fresh && (tm_q == lim);

  always_comb begin
    tm_d  = tm_q;
    ph_d  = ph_q;
    ev_d  = 1'b0;
    idx_d = idx_q;
    if (!win_any) begin
      tm_d = '0;
      ph_d = PH_FIRST;
    end else if (fresh) begin
      ev_d  = 1'b1;
      idx_d = win_idx;
      tm_d  = '0;
      ph_d  = PH_FIRST;
    end else if (due) begin
      ev_d  = 1'b1;
      idx_d = win_idx;
      tm_d  = '0;
      ph_d  = PH_AGAIN;
    end else begin
      tm_d = tm_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_q      <= '0;
      ph_q      <= PH_FIRST;
      prv_any_q <= 1'b0;
      prv_idx_q <= '0;
      ev_q      <= 1'b0;
      idx_q     <= '0;
      held_q    <= 1'b0;
    end else begin
      tm_q      <= tm_d;
      ph_q      <= ph_d;
      prv_any_q <= win_any;
      prv_idx_q <= win_idx;
      ev_q      <= ev_d;
      idx_q     <= idx_d;
      held_q    <= win_any;
    end
  end

  assign ev_valid = ev_q;
  assign ev_idx   = idx_q;
  assign held     = held_q;

endmodule

// File: rtl/prio_keypad.sv
module prio_keypad #(
  parameter int unsigned NUM_KEYS     = 4,
  parameter int unsigned DEBOUNCE_CYC = 500000,
  parameter int unsigned HOLD_CYC     = 10000000,
  parameter int unsigned REPEAT_CYC   = 5000000,
  parameter int unsigned IDX_W        = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] key_n,
  output logic                key_valid,
  output logic [IDX_W-1:0]    key_idx,
  output logic                key_held
);

  logic [NUM_KEYS-1:0] sync_down;
  logic [NUM_KEYS-1:0] flt_down;
  logic                win_any;
  logic [IDX_W-1:0]    win_idx;

  kp_sync #(.WIDTH(NUM_KEYS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_n (key_n),
    .down  (sync_down)
  );

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_flt
    kp_filter #(.SETTLE_CYC(DEBOUNCE_CYC)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_dn (sync_down[k]),
      .flt_dn (flt_down[k])
    );
  end

  kp_prio #(.NUM_KEYS(NUM_KEYS), .IDX_W(IDX_W)) u_prio (
    .down    (flt_down),
    .any_dn  (win_any),
    .win_idx (win_idx)
  );

  kp_repeat #(
    .IDX_W      (IDX_W),
    .HOLD_CYC   (HOLD_CYC),
    .REPEAT_CYC (REPEAT_CYC)
  ) u_rpt (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_any  (win_any),
    .win_idx  (win_idx),
    .ev_valid (key_valid),
    .ev_idx   (key_idx),
    .held     (key_held)
  );

endmodule

// File: rtl/keypad_checker.sv
module keypad_checker #(
  parameter int unsigned NUM_KEYS = 4,
  parameter int unsigned IDX_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_KEYS-1:0] sync_down,
  input logic [NUM_KEYS-1:0] flt_down,
  input logic                key_valid,
  input logic [IDX_W-1:0]    key_idx,
  input logic                key_held
);

  logic [NUM_KEYS-1:0] flt_q;
  logic [NUM_KEYS-1:0] below_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flt_q <= '0;
    else        flt_q <= flt_down;
  end

  assign below_mask = (NUM_KEYS'(1) << key_idx) - NUM_KEYS'(1);

  // R2: a filtered level only moves to the value the synchronizer showed.
  for (genvar i = 0; i < NUM_KEYS; i++) begin : g_chk
    p_filter_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_down[i] != $past(flt_down[i])) |-> ($past(sync_down[i]) == flt_down[i]));
  end

  // R3: the held flag never rises without an event in the same cycle.
  p_held_rise_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_held) |-> key_valid);

  // R4: an event reports the lowest filtered key that was down.
  p_prio_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (flt_q[key_idx] && ((flt_q & below_mask) == '0)));

  // R5: an event only occurs while a key is held.
  p_event_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> key_held);

  // R9: the index only changes together with an event.
  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> $stable(key_idx));

endmodule

bind prio_keypad keypad_checker #(
  .NUM_KEYS (NUM_KEYS),
  .IDX_W    (IDX_W)
) u_keypad_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sync_down (sync_down),
  .flt_down  (flt_down),
  .key_valid (key_valid),
  .key_idx   (key_idx),
  .key_held  (key_held)
);

// File: tb/prio_keypad_tb_top.sv
module prio_keypad_tb_top;

  localparam int D = 8;
  localparam int H = 40;
  localparam int R = 20;

  logic       clk;
  logic       rst_n;
  logic [3:0] key_n;
  logic       key_valid;
  logic [1:0] key_idx;
  logic       key_held;

  int n_checks;
  int n_errors;
  bit finished;

  prio_keypad #(
    .NUM_KEYS     (4),
    .DEBOUNCE_CYC (D),
    .HOLD_CYC     (H),
    .REPEAT_CYC   (R)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_n     (key_n),
    .key_valid (key_valid),
    .key_idx   (key_idx),
    .key_held  (key_held)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model, built from the requirements ----------
  logic [3:0] m_s1, m_s2, m_flt;
  int         m_cnt [4];
  logic       m_valid, m_held, m_prev_any, m_phase;
  logic [1:0] m_idx, m_prev_idx;
  int         m_tm;

  function automatic logic [1:0] lowest(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return 2'(i);
    return 2'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_flt = '0;
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
      m_valid = 0; m_held = 0; m_prev_any = 0; m_phase = 0;
      m_idx = 0; m_prev_idx = 0; m_tm = 0;
    end else begin
      logic       any;
      logic [1:0] w;
      int         lim;
      any = |m_flt;
      w   = lowest(m_flt);
      m_valid = 0;
      if (!any) begin
        m_tm = 0; m_phase = 0;
      end else if (!m_prev_any || w != m_prev_idx) begin
        m_valid = 1; m_idx = w; m_tm = 0; m_phase = 0;
      end else begin
        lim = m_phase ? R : H;
        if (m_tm == lim - 1) begin
          m_valid = 1; m_idx = w; m_tm = 0; m_phase = 1;
        end else m_tm++;
      end
      m_held = any; m_prev_any = any; m_prev_idx = w;
      for (int i = 0; i < 4; i++) begin
        if (m_s2[i] == m_flt[i]) m_cnt[i] = 0;
        else if (m_cnt[i] == D - 1) begin m_flt[i] = m_s2[i]; m_cnt[i] = 0; end
        else m_cnt[i]++;
      end
      m_s2 = m_s1;
      m_s1 = ~key_n;
    end
  end

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(key_valid == m_valid, "R3 valid vs model", key_valid, m_valid);
      check(key_held == m_held, "R5 held vs model", key_held, m_held);
      check(key_idx == m_idx, "R9 idx vs model", key_idx, m_idx);
    end
  end

  // ---------------- helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_events(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (key_valid) c++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    int c;
    process::self().srandom(32'd1234);
    n_checks = 0; n_errors = 0; finished = 0;
    key_n = 4'hF;
    rst_n = 1'b0;
    tick(3);
    check(key_valid == 0 && key_held == 0 && key_idx == 0, "R1 outputs in reset",
          {key_valid, key_held, key_idx}, 0);
    rst_n = 1'b1;
    tick(1);
    check(key_valid == 0 && key_held == 0 && key_idx == 0, "R1 outputs after reset",
          {key_valid, key_held, key_idx}, 0);
    tick(5);

    // R2: glitch one cycle too short is ignored.
    key_n[1] = 1'b0;
    tick(D - 1);
    key_n[1] = 1'b1;
    count_events(30, c);
    check(c == 0, "R2 short press ignored", c, 0);
    check(key_held == 0, "R2 held after short press", key_held, 0);

    // R3: press of key 2, event exactly D+3 edges later.
    key_n[2] = 1'b0;
    count_events(D + 2, c);
    check(c == 0, "R3 no early event", c, 0);
    tick(1);
    check(key_valid == 1 && key_idx == 2, "R3 first event key 2", {key_valid, key_idx}, 6);
    check(key_held == 1, "R5 held with key 2", key_held, 1);
    tick(1);
    check(key_valid == 0, "R3 strobe one cycle", key_valid, 0);
    // R6: repeats at H, H+R, H+2R after the first event (one cycle consumed).
    count_events(H + 2 * R - 1, c);
    check(c == 3, "R6 repeat count", c, 3);
    check(key_valid == 1, "R6 repeat on schedule", key_valid, 1);

    // R8: release glitch of D-1 cycles inside a repeat window.
    c = 0;
    for (int i = 1; i <= R; i++) begin
      @(negedge clk);
      if (key_valid) c++;
      if (i == 2) key_n[2] = 1'b1;
      if (i == 2 + D - 1) key_n[2] = 1'b0;
    end
    check(c == 1, "R8 glitch keeps repeat timing", c, 1);
    check(key_valid == 1, "R8 repeat lands at window end", key_valid, 1);
    check(key_held == 1, "R8 still held", key_held, 1);

    // R5/R10: real release, then a new press.
    key_n[2] = 1'b1;
    count_events(D + 2, c);
    check(c == 0, "R10 no event on release", c, 0);
    check(key_held == 1, "R5 held before release accepted", key_held, 1);
    tick(1);
    check(key_held == 0, "R5 held drops", key_held, 0);
    tick(10);
    key_n[2] = 1'b0;
    tick(D + 3);
    check(key_valid == 1 && key_idx == 2, "R10 new first event", {key_valid, key_idx}, 6);
    key_n[2] = 1'b1;
    tick(30);

    // R4: keys 1 and 3 together, key 1 wins.
    key_n[1] = 1'b0; key_n[3] = 1'b0;
    count_events(D + 2, c);
    check(c == 0, "R4 no early event", c, 0);
    tick(1);
    check(key_valid == 1 && key_idx == 1, "R4 lowest index wins", {key_valid, key_idx}, 5);
    // R7: releasing key 1 uncovers key 3.
    key_n[1] = 1'b1;
    count_events(D + 2, c);
    check(c == 0, "R7 no event before handover", c, 0);
    tick(1);
    check(key_valid == 1 && key_idx == 3, "R7 fresh event key 3", {key_valid, key_idx}, 7);
    count_events(H - 1, c);
    check(c == 0, "R7 timing restarted", c, 0);
    tick(1);
    check(key_valid == 1 && key_idx == 3, "R7 repeat after full hold", {key_valid, key_idx}, 7);
    key_n = 4'hF;
    tick(30);

    // Coincidence: key 0 accepted on the edge key 2's first repeat is due.
    key_n[2] = 1'b0;
    tick(H);
    key_n[0] = 1'b0;
    count_events(D + 2, c);
    check(c == 0, "R7 no stray repeat of key 2", c, 0);
    tick(1);
    check(key_valid == 1 && key_idx == 0, "R7 winner beats due repeat", {key_valid, key_idx}, 4);
    tick(1);
    check(key_valid == 0, "R3 single strobe at coincidence", key_valid, 0);
    count_events(H - 2, c);
    check(c == 0, "R7 restart after coincidence", c, 0);
    tick(1);
    check(key_valid == 1 && key_idx == 0, "R6 key 0 repeat", {key_valid, key_idx}, 4);

    // R1: reset while a key is held.
    rst_n = 1'b0;
    tick(1);
    check(key_valid == 0 && key_held == 0 && key_idx == 0, "R1 mid-run reset",
          {key_valid, key_held, key_idx}, 0);
    key_n = 4'hF;
    tick(2);
    rst_n = 1'b1;
    tick(5);

    // Random segments checked by the model.
    for (int s = 0; s < 120; s++) begin
      int len;
      key_n = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) len = $urandom_range(1, D);
      else len = $urandom_range(D, 3 * H);
      tick(len);
    end
    key_n = 4'hF;
    tick(40);
    check(key_held == 0, "R5 idle at end", key_held, 0);

    finish_run();
  end

endmodule